// File: doc/BRIEF.md
# Restoring Unsigned Divider

This block divides one N-bit unsigned integer by another through repeated trial subtraction. A pulse on `start` captures both operands. The divisor goes into the upper half of a double-width divisor register. The dividend goes into the lower half of a double-width partial-remainder register. The quotient register is cleared.

Each iteration does the following in order:

- It subtracts the divisor register from the partial remainder.
- If the difference is non-negative, the difference is kept and a 1 is shifted into the quotient.
- If the difference is negative, the partial remainder is restored to its value before the subtraction and a 0 is shifted in.
- In both cases, the divisor register then shifts right by one bit.

After N+1 iterations the quotient and remainder are presented, and `done` holds them until the next start. A zero divisor skips the iterations entirely. It raises an error flag, returns an all-ones quotient and returns the dividend as the remainder.

The controller has three states:

- IDLE: after reset.
- ITERATE: one trial step per clock.
- FINISHED: results are valid.

The state changes as follows:

- IDLE→ITERATE is the accept of a start with a nonzero divisor.
- IDLE→FINISHED is the accept of a start with a zero divisor.
- ITERATE→FINISHED is taken on the last step.
- FINISHED→ITERATE and FINISHED→FINISHED are the same two accepts, made from the finished state.
- ITERATE ignores `start`.

Top module: `restoring_divider`

## Requirements
- R1: For a nonzero divisor, `quotient` equals floor(dividend/divisor) and `remainder` equals dividend mod divisor, using the operands sampled at the accepted start.
- R2: `busy` is high for exactly N+1 clock cycles after an accepted start with a nonzero divisor (N+1 trial steps), and `done` rises on the cycle that follows the last of them.
- R3: While `done` is high and no start arrives, `done`, `quotient`, `remainder` and `div_by_zero` do not change.
- R4: A `start` pulse while `busy` is high is ignored: the running division finishes with its original operands and latency.
- R5: A start with divisor 0 sets `div_by_zero`, makes `quotient` all ones and `remainder` equal to the dividend, and raises `done` one cycle after the accept, with no busy cycles.
- R6: After reset, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all 0.
- R7: A start with a nonzero divisor clears `div_by_zero` from the cycle after the accept, and a start in the finished state is accepted like one in idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a division with the present operands (ignored while busy) |
| dividend | input | N | Unsigned dividend |
| divisor | input | N | Unsigned divisor |
| busy | output | 1 | Trial steps in progress |
| done | output | 1 | Results valid and held |
| quotient | output | N | Unsigned quotient |
| remainder | output | N | Unsigned remainder |
| div_by_zero | output | 1 | Last division had a zero divisor |

## Verification
On every cycle, the checker verifies the following:

- The rebuilt identity quotient×divisor+remainder equals the dividend, with the remainder below the divisor.
- The count of busy cycles before each completion is N+1.
- Held results do not move while `done` is high.
- A busy period can only end in `done`.
- The zero-divisor shortcut produces its flag and values in the next cycle.
- The flag clears after a nonzero start.

Only the bench scenarios show the following:

- Operands supplied during a busy period really are discarded.
- Back-to-back and zero-divisor starts from the finished state produce the right sequence of results.
- The reset values are correct.
- The exact values hold for boundary operands: zero dividend, equal operands, divisor 1 and all-ones values.

// File: rtl/rdiv_pkg.sv
package rdiv_pkg;

    // Controller states of the restoring divider
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ITERATE  = 2'd1,
        ST_FINISHED = 2'd2
    } rdiv_state_e;

endpackage

// File: rtl/rdiv_trial.sv
// One trial step: subtract, test the sign, keep or restore.
module rdiv_trial #(
    parameter int W2 = 64
) (
    input  logic [W2-1:0] part_rem_i,
    input  logic [W2-1:0] dvsr_i,
    output logic [W2-1:0] part_rem_o,
    output logic          qbit_o
);
    logic [W2:0] diff;

    always_comb begin
        diff   = {1'b0, part_rem_i} - {1'b0, dvsr_i};
        // Sign bit of the extended difference set means the trial went negative
        qbit_o = ~diff[W2];
        // Negative trial: restoring equals taking back the pre-subtraction value
        part_rem_o = qbit_o ? diff[W2-1:0] : part_rem_i;
    end
endmodule

// File: rtl/rdiv_step_counter.sv
// Counts trial steps and flags the final one.
module rdiv_step_counter #(
    parameter int STEPS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic advance,
    output logic last_step
);
    localparam int CW = $clog2(STEPS + 1);

    logic [CW-1:0] count_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (clear) begin
            count_q <= '0;
        end else if (advance) begin
            count_q <= count_q + 1'b1;
        end
    end

    assign last_step = advance && (count_q == CW'(STEPS - 1));
endmodule

// File: rtl/restoring_divider.sv
module restoring_divider #(
    parameter int N = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [N-1:0] dividend,
    input  logic [N-1:0] divisor,
    output logic         busy,
    output logic         done,
    output logic [N-1:0] quotient,
    output logic [N-1:0] remainder,
    output logic         div_by_zero
);
    import rdiv_pkg::*;

    localparam int W2    = 2 * N;
    localparam int STEPS = N + 1;
    localparam int QW    = N + 1;

    rdiv_state_e   state_q, state_d;
    logic [W2-1:0] part_rem_q;
    logic [W2-1:0] dvsr_q;
    logic [QW-1:0] quo_q;
    logic          dz_q;

    logic [W2-1:0] part_rem_nxt;
    logic          qbit;
    logic          last_step;
    logic          accept;
    logic          zero_div;
    logic          stepping;

    assign zero_div = (divisor == '0);
    assign accept   = start && (state_q != ST_ITERATE);
    assign stepping = (state_q == ST_ITERATE);

    rdiv_trial #(.W2(W2)) u_trial (
        .part_rem_i (part_rem_q),
        .dvsr_i     (dvsr_q),
        .part_rem_o (part_rem_nxt),
        .qbit_o     (qbit)
    );

    rdiv_step_counter #(.STEPS(STEPS)) u_steps (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept),
        .advance   (stepping),
        .last_step (last_step)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE, ST_FINISHED: begin
                if (start) begin
                    state_d = zero_div ? ST_FINISHED : ST_ITERATE;
                end
            end
            ST_ITERATE: begin
                if (last_step) begin
                    state_d = ST_FINISHED;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Operand and result registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            part_rem_q <= '0;
            dvsr_q     <= '0;
            quo_q      <= '0;
            dz_q       <= 1'b0;
        end else if (accept) begin
            part_rem_q <= {{N{1'b0}}, dividend};
            dvsr_q     <= {divisor, {N{1'b0}}};
            quo_q      <= zero_div ? '1 : '0;
            dz_q       <= zero_div;
        end else if (stepping) begin
            part_rem_q <= part_rem_nxt;
            quo_q      <= {quo_q[QW-2:0], qbit};
            dvsr_q     <= dvsr_q >> 1;
        end
    end

    // Outputs
    always_comb begin
        busy        = (state_q == ST_ITERATE);
        done        = (state_q == ST_FINISHED);
        quotient    = quo_q[N-1:0];
        remainder   = part_rem_q[N-1:0];
        div_by_zero = dz_q;
    end
endmodule

// File: rtl/rdiv_checker.sv
module rdiv_checker #(
    parameter int N = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic [N-1:0] dividend,
    input logic [N-1:0] divisor,
    input logic         busy,
    input logic         done,
    input logic [N-1:0] quotient,
    input logic [N-1:0] remainder,
    input logic         div_by_zero
);
    localparam int W2 = 2 * N;
    localparam int BW = $clog2(N + 2) + 1;

    logic [N-1:0]  cap_a, cap_b;
    logic [BW-1:0] busy_cnt;
    logic [W2-1:0] rebuilt;
    logic          acc;

    assign acc = start && !busy;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_a    <= '0;
            cap_b    <= '0;
            busy_cnt <= '0;
        end else if (acc) begin
            cap_a    <= dividend;
            cap_b    <= divisor;
            busy_cnt <= '0;
        end else if (busy) begin
            busy_cnt <= busy_cnt + 1'b1;
        end
    end

    always_comb begin
        rebuilt = W2'(quotient) * W2'(cap_b) + W2'(remainder);
    end

    // R1: results reconstruct the captured dividend
    a_r1_exact_result: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && !div_by_zero |-> (rebuilt == W2'(cap_a)) && (remainder < cap_b));

    // R2: completion after exactly N+1 busy cycles
    a_r2_step_count: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) && !div_by_zero |-> busy_cnt == BW'(N + 1));

    // R3: results held while finished
    a_r3_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done && $stable(quotient) && $stable(remainder) && $stable(div_by_zero));

    // R4: a busy period ends only in done
    a_r4_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> busy || done);

    // R5: zero-divisor shortcut
    a_r5_zero_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        acc && divisor == '0 |=> done && !busy && div_by_zero && quotient == '1
                                  && remainder == $past(dividend));

    // R7: nonzero start clears the flag
    a_r7_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        acc && divisor != '0 |=> !div_by_zero && busy);
endmodule

bind restoring_divider rdiv_checker #(.N(N)) i_rdiv_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .dividend    (dividend),
    .divisor     (divisor),
    .busy        (busy),
    .done        (done),
    .quotient    (quotient),
    .remainder   (remainder),
    .div_by_zero (div_by_zero)
);

// File: tb/test_restoring_divider.sv
module test_restoring_divider;
    localparam int WIDTH      = 32;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [WIDTH-1:0] dividend = '0;
    logic [WIDTH-1:0] divisor = '0;
    logic             busy, done, div_by_zero;
    logic [WIDTH-1:0] quotient, remainder;

    typedef struct {
        logic [WIDTH-1:0] q;
        logic [WIDTH-1:0] r;
        logic             dz;
        int               c0;
    } exp_t;

    exp_t sb[$];
    int   vectors = 0;
    int   miscompares = 0;
    int   cyc = 0;
    logic done_prev = 1'b0;
    logic [31:0] seed = 32'h1234_5678;

    restoring_divider #(.N(WIDTH)) i_restoring_divider (
        .clk(clk), .rst_n(rst_n), .start(start),
        .dividend(dividend), .divisor(divisor),
        .busy(busy), .done(done),
        .quotient(quotient), .remainder(remainder),
        .div_by_zero(div_by_zero)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check_val(input string req, input string what,
                             input logic [63:0] act, input logic [63:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    // Driver: waits for the block to accept, then pushes the expected item
    task automatic drive_div(input logic [WIDTH-1:0] a, input logic [WIDTH-1:0] b);
        exp_t e;
        @(negedge clk);
        while (busy) @(negedge clk);
        dividend = a;
        divisor  = b;
        start    = 1'b1;
        e.dz = (b == '0);
        e.q  = e.dz ? '1 : a / b;
        e.r  = e.dz ? a : a % b;
        e.c0 = cyc + 1;
        sb.push_back(e);
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!done) @(negedge clk);
    endtask

    function automatic logic [31:0] next_rand();
        seed = seed * 32'd1664525 + 32'd1013904223;
        return seed;
    endfunction

    // Monitor: a fresh result shows up as done rising, or done with start consumed
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_PERIOD/4);
            if (rst_n) begin
                if (done && (start || !done_prev)) begin
                    if (sb.size() == 0) begin
                        check_val("R4", "unexpected result count", 64'd1, 64'd0);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        check_val(e.dz ? "R5" : "R1", "quotient", 64'(quotient), 64'(e.q));
                        check_val(e.dz ? "R5" : "R1", "remainder", 64'(remainder), 64'(e.r));
                        check_val(e.dz ? "R5" : "R7", "div_by_zero", 64'(div_by_zero), 64'(e.dz));
                        // R2 latency (0 for the zero-divisor shortcut, R5)
                        check_val(e.dz ? "R5" : "R2", "latency",
                                  64'(cyc - e.c0), e.dz ? 64'd0 : 64'(WIDTH + 1));
                    end
                end
                done_prev = done;
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        miscompares++;
        vectors++;
        $display("FAIL watchdog: actual %0d cycles expected completion earlier", WATCHDOG);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R6: reset state
        check_val("R6", "busy", 64'(busy), 64'd0);
        check_val("R6", "done", 64'(done), 64'd0);
        check_val("R6", "div_by_zero", 64'(div_by_zero), 64'd0);
        check_val("R6", "quotient", 64'(quotient), 64'd0);
        check_val("R6", "remainder", 64'(remainder), 64'd0);

        // R1 boundary operands
        drive_div(32'd100, 32'd7);
        drive_div(32'd0, 32'd5);
        drive_div(32'd9, 32'd9);
        drive_div(32'd8, 32'd9);
        drive_div(32'hFFFF_FFFF, 32'd1);
        drive_div(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        drive_div(32'hFFFF_FFFE, 32'hFFFF_FFFF);
        drive_div(32'hFFFF_FFFF, 32'h8000_0000);
        drive_div(32'h8000_0000, 32'd3);

        // R5 zero divisor, then R7 back-to-back from finished state
        drive_div(32'hDEAD_BEEF, 32'd0);
        drive_div(32'd5, 32'd0);
        drive_div(32'd77, 32'd10);

        // R3 hold while finished
        wait_done();
        repeat (6) @(negedge clk);
        check_val("R3", "done held", 64'(done), 64'd1);
        check_val("R3", "quotient held", 64'(quotient), 64'd7);
        check_val("R3", "remainder held", 64'(remainder), 64'd7);
        check_val("R3", "busy low", 64'(busy), 64'd0);

        // R4 start while busy is ignored
        drive_div(32'd1000, 32'd7);
        repeat (5) @(negedge clk);
        dividend = 32'd99;
        divisor  = 32'd0;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        check_val("R4", "quotient after ignored start", 64'(quotient), 64'd142);
        check_val("R4", "flag after ignored start", 64'(div_by_zero), 64'd0);

        // R1 pseudo-random operands of varied magnitude
        for (int i = 0; i < 24; i++) begin
            logic [31:0] a, b;
            a = next_rand();
            b = next_rand() >> (next_rand() % 32);
            if (b == '0) b = 32'd3;
            drive_div(a, b);
        end

        repeat (WIDTH + 6) @(negedge clk);
        check_val("R1", "pending results", 64'(sb.size()), 64'd0);
        report();
    end
endmodule